// File: doc/BRIEF.md
# Line Loss-of-Signal Monitor

This block watches the positive and negative pulse rails of a bipolar line interface and samples both on every line clock. A run of samples with no pulse on either rail is counted. When that run reaches the threshold (180 samples by default), the block declares an internal loss of signal. An external loss indication from a line receiver chip is also accepted. It passes through a two-stage synchronizer and is OR-ed with the internal result.

A control bit in an eight-bit configuration/status register can mask the internal run detector, which leaves the external pin as the only source. The same register reports the combined loss flag as a read-only bit. Three other line conditions (alarm indication, idle and out-of-frame) arrive as plain inputs and are shown in read-only bits. Three further bits are writable framing controls that the block only stores.

The zero-run detector is a three-state machine:
- `ZR_LIVE`: the last sample carried a pulse and the count is 0.
- `ZR_RUN`: zeros are being counted below the threshold.
- `ZR_LOSS`: the threshold has been reached and the count is held.

Its transitions are as follows:
- LIVE→RUN on a zero sample.
- RUN→RUN on a zero sample while the count stays below the threshold.
- RUN→LOSS on the zero sample that completes the threshold.
- LOSS→LOSS on further zero samples.
- RUN→LIVE and LOSS→LIVE on any sample with a pulse.
- LIVE→LIVE on pulses.

Reset enters `ZR_LOSS`.

Top module: `line_los_monitor`

## Requirements
- R1: Internal loss is declared in the cycle after the 180th consecutive sample with both rails at 0. A run of 179 zero samples followed by a pulse does not declare it.
- R2: A sample with a 1 on either rail restarts the run count at zero. The same sample clears internal loss, which is visible after that clock edge.
- R3: The run count saturates at the threshold. Internal loss stays asserted for any zero run longer than the threshold, however long.
- R4: The external loss pin reaches the loss output two clock edges after it is sampled, in both directions.
- R5: With the disable bit at 0, the loss output is the OR of internal loss and the synchronized external pin.
- R6: With the disable bit at 1, the loss output follows only the synchronized external pin, whatever the rails carry.
- R7: The register read value has the following layout. Bit 7 is the alarm-indication input, bit 6 is the loss output, bit 5 is the idle input and bit 4 is the out-of-frame input. Bits 3..0 are writable controls, and bit 3 is the loss-detector disable. A write at offset 0x0E updates bits 3..0 from write data bits 3..0 after the clock edge.
- R8: Write data bits 7..4 have no effect on the register. A write at any offset other than 0x0E changes nothing.
- R9: During and right after reset the loss output is 1 and the control bits are 0, so the register reads 0x50 when only the out-of-frame input is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line clock; one rail sample per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rail_pos | input | 1 | Positive pulse rail sample |
| rail_neg | input | 1 | Negative pulse rail sample |
| ext_los_pin | input | 1 | Asynchronous loss indication from the line receiver |
| ais_flag | input | 1 | Alarm indication status, shown in register bit 7 |
| idle_flag | input | 1 | Idle status, shown in register bit 5 |
| oof_flag | input | 1 | Out-of-frame status, shown in register bit 4 |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register write offset |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read value |
| los_out | output | 1 | Combined loss-of-signal flag |

## Verification
The internal run detector and the external pin path can change the loss output in the same cycle. The bench provokes this by raising the external pin exactly two samples before a 180-sample zero run completes, and by dropping it while a run is held. A write of the disable bit can also land on the cycle that a run completes. A reference model in the bench follows queue-held pin history, an integer run count and the written control value, and it judges each of these cycles by comparing the loss output and the full register value on every clock.

// File: rtl/los_pkg.sv
package los_pkg;

    typedef enum logic [1:0] {
        ZR_LIVE = 2'd0,
        ZR_RUN  = 2'd1,
        ZR_LOSS = 2'd2
    } zr_state_e;

    localparam int REG_W      = 8;
    localparam int CTL_W      = 4;
    localparam int BIT_AIS    = 7;
    localparam int BIT_LOS    = 6;
    localparam int BIT_IDLE   = 5;
    localparam int BIT_OOF    = 4;
    localparam int BIT_DIS    = 3;

endpackage

// File: rtl/los_sync.sv
module los_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= d_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain_q <= '0;
                else        chain_q <= {chain_q[STAGES-2:0], d_async};
            end
        end
    endgenerate

    always_comb q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/los_zero_run.sv
module los_zero_run
    import los_pkg::*;
#(
    parameter int RUN_THRESH = 180,
    localparam int CNT_W = $clog2(RUN_THRESH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pos,
    input  logic             neg,
    output logic             los_int,
    output logic [CNT_W-1:0] run_cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(RUN_THRESH);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(RUN_THRESH - 1);

    zr_state_e        state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             zero_smp;

    always_comb zero_smp = ~pos & ~neg;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ZR_LOSS;
            cnt_q   <= CNT_MAX;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ZR_LIVE: begin
                if (zero_smp) begin
                    if (RUN_THRESH == 1) begin
                        state_d = ZR_LOSS;
                        cnt_d   = CNT_MAX;
                    end else begin
                        state_d = ZR_RUN;
                        cnt_d   = CNT_W'(1);
                    end
                end else begin
                    cnt_d = '0;
                end
            end
            ZR_RUN: begin
                if (!zero_smp) begin
                    state_d = ZR_LIVE;
                    cnt_d   = '0;
                end else if (cnt_q == CNT_LAST) begin
                    state_d = ZR_LOSS;
                    cnt_d   = CNT_MAX;
                end else begin
                    cnt_d = cnt_q + CNT_W'(1);
                end
            end
            ZR_LOSS: begin
                if (!zero_smp) begin
                    state_d = ZR_LIVE;
                    cnt_d   = '0;
                end else begin
                    cnt_d = CNT_MAX;
                end
            end
            default: begin
                state_d = ZR_LIVE;
                cnt_d   = '0;
            end
        endcase
    end

    // outputs
    always_comb begin
        los_int = (state_q == ZR_LOSS);
        run_cnt = cnt_q;
    end

    AST_CNT_BOUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_MAX) else $error("count beyond threshold"); // R3

    AST_PULSE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (pos | neg) |=> (!los_int && run_cnt == '0)) else $error("pulse did not clear"); // R2

    AST_LOSS_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(los_int) |-> ($past(run_cnt) == CNT_LAST)) else $error("loss without full run"); // R1

    AST_LOSS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (los_int && !pos && !neg) |=> los_int) else $error("loss dropped during zeros"); // R3

endmodule

// File: rtl/los_cfg_reg.sv
module los_cfg_reg
    import los_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter logic [ADDR_W-1:0] REG_OFFSET = ADDR_W'(14)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    input  logic              ais_in,
    input  logic              los_in,
    input  logic              idle_in,
    input  logic              oof_in,
    output logic [REG_W-1:0]  rd_data,
    output logic              los_disable
);

    logic [CTL_W-1:0] ctl_q;
    logic             wr_hit;

    always_comb wr_hit = wr_en && (wr_addr == REG_OFFSET);

    always_ff @(posedge clk) begin
        if (!rst_n)      ctl_q <= '0;
        else if (wr_hit) ctl_q <= wr_data[CTL_W-1:0];
    end

    always_comb begin
        rd_data              = '0;
        rd_data[BIT_AIS]     = ais_in;
        rd_data[BIT_LOS]     = los_in;
        rd_data[BIT_IDLE]    = idle_in;
        rd_data[BIT_OOF]     = oof_in;
        rd_data[CTL_W-1:0]   = ctl_q;
        los_disable          = ctl_q[BIT_DIS];
    end

    AST_CTL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (rd_data[CTL_W-1:0] == $past(wr_data[CTL_W-1:0]))) else $error("write lost"); // R7

    AST_CTL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(rd_data[CTL_W-1:0])) else $error("controls changed"); // R8

endmodule

// File: rtl/line_los_monitor.sv
module line_los_monitor
    import los_pkg::*;
#(
    parameter int RUN_THRESH  = 180,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = 4,
    parameter logic [ADDR_W-1:0] REG_OFFSET = ADDR_W'(14)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rail_pos,
    input  logic              rail_neg,
    input  logic              ext_los_pin,
    input  logic              ais_flag,
    input  logic              idle_flag,
    input  logic              oof_flag,
    input  logic              cfg_wr,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [REG_W-1:0]  cfg_wdata,
    output logic [REG_W-1:0]  cfg_rdata,
    output logic              los_out
);

    localparam int CNT_W = $clog2(RUN_THRESH + 1);

    logic             int_los;
    logic [CNT_W-1:0] run_cnt;
    logic             ext_q;
    logic             dis;

    los_zero_run #(.RUN_THRESH(RUN_THRESH)) u_run (
        .clk     (clk),
        .rst_n   (rst_n),
        .pos     (rail_pos),
        .neg     (rail_neg),
        .los_int (int_los),
        .run_cnt (run_cnt)
    );

    los_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ext_los_pin),
        .q_sync  (ext_q)
    );

    always_comb los_out = (int_los & ~dis) | ext_q;

    los_cfg_reg #(.ADDR_W(ADDR_W), .REG_OFFSET(REG_OFFSET)) u_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (cfg_wr),
        .wr_addr     (cfg_addr),
        .wr_data     (cfg_wdata),
        .ais_in      (ais_flag),
        .los_in      (los_out),
        .idle_in     (idle_flag),
        .oof_in      (oof_flag),
        .rd_data     (cfg_rdata),
        .los_disable (dis)
    );

    AST_EXT_FORCES: assert property (@(posedge clk) disable iff (!rst_n)
        ext_q |-> los_out) else $error("external loss not shown"); // R5

    AST_INT_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (int_los && !dis) |-> los_out) else $error("internal loss not shown"); // R5

    AST_DIS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
        (dis && !ext_q) |-> !los_out) else $error("masked detector leaked"); // R6

    generate
        if (SYNC_STAGES == 2) begin : g_lat_chk
            AST_EXT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
                $changed(ext_q) |-> (ext_q == $past(ext_los_pin, 2))) else $error("sync latency"); // R4
        end
    endgenerate

endmodule

// File: tb/line_los_monitor_tb.sv
module line_los_monitor_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rail_pos = 1'b0, rail_neg = 1'b0, ext_los_pin = 1'b0;
    logic       ais_flag = 1'b0, idle_flag = 1'b0, oof_flag = 1'b1;
    logic       cfg_wr = 1'b0;
    logic [3:0] cfg_addr = 4'h0;
    logic [7:0] cfg_wdata = 8'h00;
    logic [7:0] cfg_rdata;
    logic       los_out;

    always #2 clk = ~clk;

    line_los_monitor u_dut (
        .clk(clk), .rst_n(rst_n), .rail_pos(rail_pos), .rail_neg(rail_neg),
        .ext_los_pin(ext_los_pin), .ais_flag(ais_flag), .idle_flag(idle_flag),
        .oof_flag(oof_flag), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .los_out(los_out)
    );

    int    n_chk = 0, n_fail = 0;
    bit    done = 0;
    string phase = "R9";

    // reference model
    int    m_zeros;
    bit    m_int;
    bit    m_ext;
    bit    m_pin_hist[$];
    bit [3:0] m_ctl;

    function automatic bit exp_los();
        return (m_int && !m_ctl[3]) || m_ext;
    endfunction

    function automatic bit [7:0] exp_reg();
        return {ais_flag, exp_los(), idle_flag, oof_flag, m_ctl};
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        m_zeros = 180; m_int = 1; m_ext = 0; m_ctl = 4'h0;
        m_pin_hist.delete();
        m_pin_hist.push_back(1'b0);
    endtask

    // one clock: drive, edge, update model, compare
    task automatic cyc(input bit p, input bit n, input bit e,
                       input bit we = 0, input bit [3:0] a = 4'h0, input bit [7:0] wd = 8'h00);
        rail_pos = p; rail_neg = n; ext_los_pin = e;
        cfg_wr = we; cfg_addr = a; cfg_wdata = wd;
        @(posedge clk);
        if (!p && !n) begin
            if (m_zeros < 180) m_zeros++;
        end else m_zeros = 0;
        m_int = (m_zeros >= 180);
        m_pin_hist.push_back(e);
        m_ext = m_pin_hist.pop_front();
        if (we && a == 4'hE) m_ctl = wd[3:0];
        #1;
        chk(phase, {7'b0, los_out}, {7'b0, exp_los()});
        chk(phase, cfg_rdata, exp_reg());
        cfg_wr = 0;
    endtask

    task automatic zeros(input int k, input bit e = 0);
        for (int i = 0; i < k; i++) cyc(0, 0, e);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        chk("R9", {7'b0, los_out}, 8'h01);
        chk("R9", cfg_rdata, 8'h50);
        rst_n = 1;
        zeros(3);
        chk("R9", cfg_rdata, 8'h50);

        phase = "R2";
        cyc(1, 0, 0);
        chk("R2", {7'b0, los_out}, 8'h00);
        cyc(0, 1, 0); cyc(1, 1, 0); cyc(0, 0, 0); cyc(1, 0, 0);

        phase = "R1";
        zeros(179);
        chk("R1", {7'b0, los_out}, 8'h00);
        cyc(0, 1, 0);
        zeros(179);
        chk("R1", {7'b0, los_out}, 8'h00);
        zeros(1);
        chk("R1", {7'b0, los_out}, 8'h01);

        phase = "R3";
        zeros(400);
        chk("R3", {7'b0, los_out}, 8'h01);
        cyc(0, 1, 0);
        chk("R3", {7'b0, los_out}, 8'h00);

        phase = "R4";
        cyc(1, 0, 1);
        chk("R4", {7'b0, los_out}, 8'h00);
        cyc(0, 1, 1);
        chk("R4", {7'b0, los_out}, 8'h01);
        cyc(1, 0, 0);
        chk("R4", {7'b0, los_out}, 8'h01);
        cyc(0, 1, 0);
        chk("R4", {7'b0, los_out}, 8'h00);

        phase = "R5";
        // external rises exactly as the run completes
        zeros(178);
        zeros(2, 1);
        chk("R5", {7'b0, los_out}, 8'h01);
        zeros(5, 0);
        chk("R5", {7'b0, los_out}, 8'h01);
        cyc(1, 0, 0);

        phase = "R6";
        cyc(1, 0, 0, 1, 4'hE, 8'h08);
        zeros(250);
        chk("R6", {7'b0, los_out}, 8'h00);
        zeros(2, 1);
        chk("R6", {7'b0, los_out}, 8'h01);
        zeros(2, 0);
        chk("R6", {7'b0, los_out}, 8'h00);
        // disable cleared on the cycle the detector is already in loss
        cyc(0, 0, 0, 1, 4'hE, 8'h00);
        chk("R6", {7'b0, los_out}, 8'h01);
        cyc(0, 1, 0);
        // disable set on the very cycle a run completes
        zeros(179);
        cyc(0, 0, 0, 1, 4'hE, 8'h08);
        chk("R6", {7'b0, los_out}, 8'h00);

        phase = "R7";
        cyc(1, 0, 0, 1, 4'hE, 8'h07);
        chk("R7", cfg_rdata, 8'h17);
        ais_flag = 1; idle_flag = 1; oof_flag = 0;
        cyc(0, 1, 0);
        chk("R7", cfg_rdata, 8'hA7);
        ais_flag = 0; idle_flag = 0; oof_flag = 1;
        cyc(1, 1, 0);

        phase = "R8";
        cyc(1, 0, 0, 1, 4'hE, 8'hF0);
        chk("R8", cfg_rdata, 8'h10);
        cyc(1, 0, 0, 1, 4'h3, 8'h0F);
        chk("R8", cfg_rdata, 8'h10);
        cyc(1, 0, 0, 1, 4'hD, 8'h08);
        zeros(190);
        chk("R8", {7'b0, los_out}, 8'h01);

        phase = "R9";
        rst_n = 0;
        model_reset();
        cyc(1, 0, 0);
        chk("R9", cfg_rdata, 8'h50);
        rst_n = 1;
        cyc(1, 0, 0);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    // while reset is held the model stays in its reset state
    always @(posedge clk) if (!rst_n) model_reset();

endmodule